// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a host fetch 32-bit words from serial NOR flash devices using ordinary read cycles. The host presents a byte address and a one-cycle read strobe. The address is compared against a set of programmable windows, one per chip select. Each window covers a whole number of 1 MB pages.

When a read lands in an enabled window, the engine builds a complete flash read transaction for that device. The per-device control word supplies the opcode, the dummy byte count and the data lane width. The engine then drives the serial pins through the opcode, address, dummy and data phases, and hands the word back with a one-cycle ready pulse. A read that cannot be served completes at once with an error flag.

Configuration is done through a small write port. It selects one of three registers for a given chip select: the control word, the window register, or a shared register that holds the address width bit for each chip select.

Top module: `flash_window_reader`

## Requirements
- R1: A read is routed to a chip select when that chip select's window register is nonzero and the address page (address bits 27:20) lies between the start page (register bits 11:4) and the last page (register bits 27:20), both ends included. The flash address sent is the host address minus start page × 1 MB.
- R2: A window register holding zero never selects its chip select, whatever address is read.
- R3: When several windows contain the address, the lowest-numbered chip select is used.
- R4: A read completes in the next cycle with `hst_rdy` and `hst_err` both high for one cycle, data 0 and no chip select asserted, in three cases: the read hits no window, the address is not a multiple of 4, or the control word mode field (bits 1:0) is not 01.
- R5: The header goes out on `spi_io_out[0]` as the opcode (control bits 23:16) followed by the flash address, most significant bit first. The address is 3 bytes long, or 4 bytes when bit n of the address-width register (`cfg_sel`=2) is set for chip select n.
- R6: The number of dummy bytes after the address is the 3-bit value {control bit 14, control bits 7:6}, from 0 to 7.
- R7: Data bits are read on `spi_io_in[1]` in single mode. Dual mode (control bit 29) reads `spi_io_in[1:0]`, and quad mode (control bit 30, which takes priority) reads `spi_io_in[3:0]`. In each step the highest lane carries the earliest bit. The output enables are zero during the data phase.
- R8: The returned word holds the first received byte in bits 7:0 and the fourth in bits 31:24. `hst_rdy` is high for exactly one cycle per read.
- R9: `spi_sclk` runs at half the system clock. It idles low and stays high for one cycle at a time. It is high only while a chip select is low, and at most one chip select is low at a time.
- R10: Between two transactions, all chip selects stay high for at least 2 clock cycles.
- R11: After reset, all chip selects are high, `spi_sclk` and `hst_rdy` are low, and every window is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control word, 1 window, 2 address-width bits |
| cfg_cs | input | CS_W | Chip select addressed by the write |
| cfg_wdata | input | 32 | Configuration write data |
| hst_rd | input | 1 | Host read strobe, one cycle |
| hst_addr | input | ADDR_W | Host byte address |
| hst_rdata | output | 32 | Returned word, valid with hst_rdy |
| hst_rdy | output | 1 | Read complete, one-cycle pulse |
| hst_err | output | 1 | Read could not be served, one-cycle pulse with hst_rdy |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | NCS | Active-low chip selects |
| spi_io_out | output | 4 | Serial output lanes |
| spi_io_oe | output | 4 | Output enables for the lanes |
| spi_io_in | input | 4 | Serial input lanes |

## Verification
The assertions assume the host issues a read strobe only when the engine is idle. That means after the previous ready pulse and after the chip-select gap has passed. They also assume configuration writes happen only between reads. The stimulus respects both rules: each read task waits for the ready pulse and then idles for several cycles before the next access, and registers are rewritten only between reads. The flash model in the bench changes the input lanes only on falling serial clock edges, so the sampled data are always stable.

// File: rtl/fwr_pkg.sv
// Shared definitions for the flash window reader: field decoding of the
// per-chip-select control word, sequencer states and lane encodings.
package fwr_pkg;

    localparam int          PAGE_SHIFT    = 20;           // 1 MB window granularity
    localparam int          HDR_W         = 40;           // opcode plus widest address
    localparam logic [1:0]  MODE_CMD_READ = 2'b01;
    localparam logic [1:0]  SEL_CTRL      = 2'd0;
    localparam logic [1:0]  SEL_SEG       = 2'd1;
    localparam logic [1:0]  SEL_WIDE      = 2'd2;
    localparam logic [31:0] CTRL_RESET    = 32'h0003_0001; // opcode 03h, command read

    typedef enum logic [1:0] {LANE_X1, LANE_X2, LANE_X4} lane_e;

    typedef enum logic [2:0] {SQ_IDLE, SQ_HDR, SQ_DATA, SQ_END, SQ_GAP} sq_state_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic [2:0] dummy;
        lane_e      lanes;
        logic [1:0] mode;
    } rd_ctrl_t;

    // Unpack a control word; quad takes priority over dual.
    function automatic rd_ctrl_t ctrl_fields(input logic [31:0] w);
        rd_ctrl_t c;
        c.opcode = w[23:16];
        c.dummy  = {w[14], w[7:6]};
        c.mode   = w[1:0];
        if (w[30])      c.lanes = LANE_X4;
        else if (w[29]) c.lanes = LANE_X2;
        else            c.lanes = LANE_X1;
        return c;
    endfunction

endpackage

// File: rtl/fwr_cfg_regs.sv
// Configuration storage: one control word and one window register per chip
// select, plus a shared vector of address-width bits.
// Assumes writes happen only while no read is in flight.
module fwr_cfg_regs
    import fwr_pkg::*;
#(
    parameter int NCS  = 5,
    parameter int CS_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_sel,
    input  logic [CS_W-1:0]       cfg_cs,
    input  logic [31:0]           cfg_wdata,
    output logic [NCS-1:0][31:0]  ctrl_o,
    output logic [NCS-1:0][31:0]  seg_o,
    output logic [NCS-1:0]        wide_o
);

    generate
        for (genvar i = 0; i < NCS; i++) begin : g_cs
            logic [31:0] ctrl_r;
            logic [31:0] seg_r;
            logic        hit_w;

            assign hit_w = cfg_we && (cfg_cs == CS_W'(i));

            // Hold the control word and window register of this chip select.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ctrl_r <= CTRL_RESET;
                    seg_r  <= '0;
                end else if (hit_w) begin
                    if (cfg_sel == SEL_CTRL) ctrl_r <= cfg_wdata;
                    if (cfg_sel == SEL_SEG)  seg_r  <= cfg_wdata;
                end
            end

            assign ctrl_o[i] = ctrl_r;
            assign seg_o[i]  = seg_r;
        end
    endgenerate

    // Hold the per-chip-select 4-byte address enables.
    always_ff @(posedge clk) begin
        if (!rst_n)                              wide_o <= '0;
        else if (cfg_we && cfg_sel == SEL_WIDE)  wide_o <= cfg_wdata[NCS-1:0];
    end

endmodule

// File: rtl/fwr_win_decode.sv
// Window decoder: matches the host page against every enabled window and
// picks the lowest matching chip select. Returns the offset inside it.
// Assumes ADDR_W - 20 is at most 8, the width of the page fields.
module fwr_win_decode
    import fwr_pkg::*;
#(
    parameter int NCS    = 5,
    parameter int CS_W   = 3,
    parameter int ADDR_W = 28
) (
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [NCS-1:0][31:0]   seg_i,
    output logic                   hit_o,
    output logic [CS_W-1:0]        idx_o,
    output logic [ADDR_W-1:0]      off_o
);

    localparam int PG_W = ADDR_W - PAGE_SHIFT;

    logic [PG_W-1:0]           page_w;
    logic [NCS-1:0]            match_w;
    logic [NCS-1:0][PG_W-1:0]  rel_w;

    assign page_w = addr_i[ADDR_W-1 -: PG_W];

    generate
        for (genvar i = 0; i < NCS; i++) begin : g_win
            logic [PG_W-1:0] first_pg;
            logic [PG_W-1:0] last_pg;
            assign first_pg   = seg_i[i][4 +: PG_W];
            assign last_pg    = seg_i[i][20 +: PG_W];
            assign match_w[i] = (|seg_i[i]) && (page_w >= first_pg) && (page_w <= last_pg);
            assign rel_w[i]   = page_w - first_pg;
        end
    endgenerate

    // Priority pick: the lowest index is visited last and therefore wins.
    always_comb begin
        hit_o = |match_w;
        idx_o = '0;
        off_o = '0;
        for (int i = NCS - 1; i >= 0; i--) begin
            if (match_w[i]) begin
                idx_o = CS_W'(i);
                off_o = {rel_w[i], addr_i[PAGE_SHIFT-1:0]};
            end
        end
    end

endmodule

// File: rtl/fwr_spi_seq.sv
// Serial sequencer: runs one flash read (header on lane 0, dummy bytes,
// data on 1/2/4 lanes) with the serial clock at half the system clock.
// The header is driven while the serial clock is low. Input is sampled on
// the edge that raises the serial clock. Start is honoured only when idle.
module fwr_spi_seq
    import fwr_pkg::*;
#(
    parameter int NCS     = 5,
    parameter int CS_W    = 3,
    parameter int GAP_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CS_W-1:0]  cs_i,
    input  logic [31:0]      faddr_i,
    input  logic [7:0]       opcode_i,
    input  logic [2:0]       dummy_i,
    input  lane_e            lanes_i,
    input  logic             wide_i,
    output logic             idle_o,
    output logic             done_o,
    output logic [31:0]      word_o,
    output logic             sclk_o,
    output logic [NCS-1:0]   cs_n_o,
    output logic [3:0]       io_out_o,
    output logic [3:0]       io_oe_o,
    input  logic [3:0]       io_in_i
);

    localparam int GAP_W = $clog2(GAP_CYC + 1);

    sq_state_e         st_q;
    logic              sclk_q;
    logic [NCS-1:0]    csn_q;
    logic [HDR_W-1:0]  hdr_q;
    logic [6:0]        bits_q;
    logic [5:0]        steps_q;
    lane_e             lane_q;
    logic [31:0]       rx_q;
    logic              done_q;
    logic [GAP_W-1:0]  gap_q;
    logic [6:0]        hdr_bits;
    logic [5:0]        data_steps;
    logic [31:0]       rx_next;

    // Header length in serial clocks: opcode, address and dummy bytes.
    always_comb hdr_bits = 7'd8 + (wide_i ? 7'd32 : 7'd24) + {1'b0, dummy_i, 3'b000};

    // Serial clocks needed for 32 data bits at the chosen lane width.
    always_comb begin
        case (lane_q)
            LANE_X4: data_steps = 6'd8;
            LANE_X2: data_steps = 6'd16;
            default: data_steps = 6'd32;
        endcase
    end

    // Shift the sampled lanes in; the first bit ends up most significant.
    always_comb begin
        case (lane_q)
            LANE_X4: rx_next = {rx_q[27:0], io_in_i};
            LANE_X2: rx_next = {rx_q[29:0], io_in_i[1:0]};
            default: rx_next = {rx_q[30:0], io_in_i[1]};
        endcase
    end

    // Transaction state machine and serial pin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SQ_IDLE;
            sclk_q  <= 1'b0;
            csn_q   <= '1;
            hdr_q   <= '0;
            bits_q  <= '0;
            steps_q <= '0;
            lane_q  <= LANE_X1;
            rx_q    <= '0;
            done_q  <= 1'b0;
            gap_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        csn_q  <= ~(NCS'(1) << cs_i);
                        hdr_q  <= wide_i ? {opcode_i, faddr_i} : {opcode_i, faddr_i[23:0], 8'h00};
                        bits_q <= hdr_bits;
                        lane_q <= lanes_i;
                        sclk_q <= 1'b0;
                        st_q   <= SQ_HDR;
                    end
                end
                SQ_HDR: begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        hdr_q  <= {hdr_q[HDR_W-2:0], 1'b0};
                        bits_q <= bits_q - 7'd1;
                        if (bits_q == 7'd1) begin
                            steps_q <= data_steps;
                            st_q    <= SQ_DATA;
                        end
                    end
                end
                SQ_DATA: begin
                    if (!sclk_q) begin
                        sclk_q  <= 1'b1;
                        rx_q    <= rx_next;
                        steps_q <= steps_q - 6'd1;
                        if (steps_q == 6'd1) st_q <= SQ_END;
                    end else begin
                        sclk_q <= 1'b0;
                    end
                end
                SQ_END: begin
                    sclk_q <= 1'b0;
                    csn_q  <= '1;
                    done_q <= 1'b1;
                    gap_q  <= GAP_W'(GAP_CYC);
                    st_q   <= SQ_GAP;
                end
                SQ_GAP: begin
                    gap_q <= gap_q - GAP_W'(1);
                    if (gap_q == GAP_W'(1)) st_q <= SQ_IDLE;
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    assign idle_o   = (st_q == SQ_IDLE);
    assign done_o   = done_q;
    assign word_o   = {rx_q[7:0], rx_q[15:8], rx_q[23:16], rx_q[31:24]};
    assign sclk_o   = sclk_q;
    assign cs_n_o   = csn_q;
    assign io_out_o = {3'b000, hdr_q[HDR_W-1]};
    assign io_oe_o  = (st_q == SQ_HDR) ? 4'b0001 : 4'b0000;

endmodule

// File: rtl/flash_window_reader.sv
// Top: decodes host reads against the chip-select windows and either starts
// a serial flash read or completes at once with an error.
// Assumes the host strobes hst_rd only when the previous read has completed.
module flash_window_reader
    import fwr_pkg::*;
#(
    parameter int  NCS    = 5,
    parameter int  ADDR_W = 28,
    localparam int CS_W   = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [CS_W-1:0]    cfg_cs,
    input  logic [31:0]        cfg_wdata,
    input  logic               hst_rd,
    input  logic [ADDR_W-1:0]  hst_addr,
    output logic [31:0]        hst_rdata,
    output logic               hst_rdy,
    output logic               hst_err,
    output logic               spi_sclk,
    output logic [NCS-1:0]     spi_cs_n,
    output logic [3:0]         spi_io_out,
    output logic [3:0]         spi_io_oe,
    input  logic [3:0]         spi_io_in
);

    logic [NCS-1:0][31:0] ctrl_w;
    logic [NCS-1:0][31:0] seg_w;
    logic [NCS-1:0]       wide_w;
    logic                 win_hit;
    logic [CS_W-1:0]      win_idx;
    logic [ADDR_W-1:0]    win_off;
    rd_ctrl_t             sel_ctrl;
    logic                 req_ok;
    logic                 seq_idle;
    logic                 seq_done;
    logic                 seq_start;
    logic                 miss_q;
    logic [31:0]          seq_word;

    fwr_cfg_regs #(.NCS(NCS), .CS_W(CS_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_cs    (cfg_cs),
        .cfg_wdata (cfg_wdata),
        .ctrl_o    (ctrl_w),
        .seg_o     (seg_w),
        .wide_o    (wide_w)
    );

    fwr_win_decode #(.NCS(NCS), .CS_W(CS_W), .ADDR_W(ADDR_W)) dec_i (
        .addr_i (hst_addr),
        .seg_i  (seg_w),
        .hit_o  (win_hit),
        .idx_o  (win_idx),
        .off_o  (win_off)
    );

    // Fields of the control word that belongs to the selected chip select.
    always_comb sel_ctrl = ctrl_fields(ctrl_w[win_idx]);

    // A read is served only on a hit, word alignment and command-read mode.
    always_comb req_ok = win_hit && (hst_addr[1:0] == 2'b00) && (sel_ctrl.mode == MODE_CMD_READ);

    assign seq_start = hst_rd && seq_idle && req_ok;

    // Register the immediate error completion of a rejected read.
    always_ff @(posedge clk) begin
        if (!rst_n) miss_q <= 1'b0;
        else        miss_q <= hst_rd && seq_idle && !req_ok;
    end

    fwr_spi_seq #(.NCS(NCS), .CS_W(CS_W)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (seq_start),
        .cs_i     (win_idx),
        .faddr_i  (32'(win_off)),
        .opcode_i (sel_ctrl.opcode),
        .dummy_i  (sel_ctrl.dummy),
        .lanes_i  (sel_ctrl.lanes),
        .wide_i   (wide_w[win_idx]),
        .idle_o   (seq_idle),
        .done_o   (seq_done),
        .word_o   (seq_word),
        .sclk_o   (spi_sclk),
        .cs_n_o   (spi_cs_n),
        .io_out_o (spi_io_out),
        .io_oe_o  (spi_io_oe),
        .io_in_i  (spi_io_in)
    );

    assign hst_rdy   = seq_done | miss_q;
    assign hst_err   = miss_q;
    assign hst_rdata = miss_q ? 32'h0 : seq_word;

endmodule

// File: rtl/fwr_chk.sv
// Protocol checker for the flash window reader, bound to the top module.
// Assumes the host follows the one-read-at-a-time rule.
module fwr_chk #(
    parameter int NCS = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hst_rdy,
    input logic            hst_err,
    input logic            spi_sclk,
    input logic [NCS-1:0]  spi_cs_n,
    input logic [3:0]      spi_io_oe
);

    logic [1:0] hi_run_q;

    // Count consecutive cycles with every chip select released (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)           hi_run_q <= 2'd3;
        else if (&spi_cs_n)   hi_run_q <= (hi_run_q == 2'd3) ? 2'd3 : hi_run_q + 2'd1;
        else                  hi_run_q <= 2'd0;
    end

    // R9
    cs_onecold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));

    // R9
    sclk_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !(&spi_cs_n));

    // R9
    sclk_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |=> !spi_sclk);

    // R10
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&spi_cs_n) && hi_run_q != 2'd0) |-> (hi_run_q >= 2'd2));

    // R4
    err_with_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_err |-> hst_rdy);

    // R4
    err_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_err |-> (&spi_cs_n));

    // R8
    rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_rdy |=> !hst_rdy);

    // R7
    oe_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|spi_io_oe) |-> !(&spi_cs_n));

endmodule

bind flash_window_reader fwr_chk #(.NCS(NCS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_rdy   (hst_rdy),
    .hst_err   (hst_err),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n),
    .spi_io_oe (spi_io_oe)
);

// File: tb/flash_window_reader_tb_top.sv
// Scoreboard bench: the driver computes expected words and pushes them, the
// monitor pops on every ready pulse. A behavioural flash model answers reads.
module flash_window_reader_tb_top;

    localparam int NCS    = 5;
    localparam int ADDR_W = 28;
    localparam int CS_W   = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_we;
    logic [1:0]        cfg_sel;
    logic [CS_W-1:0]   cfg_cs;
    logic [31:0]       cfg_wdata;
    logic              hst_rd;
    logic [ADDR_W-1:0] hst_addr;
    logic [31:0]       hst_rdata;
    logic              hst_rdy;
    logic              hst_err;
    logic              spi_sclk;
    logic [NCS-1:0]    spi_cs_n;
    logic [3:0]        spi_io_out;
    logic [3:0]        spi_io_oe;
    logic [3:0]        fio;

    always #5 clk = ~clk;

    flash_window_reader #(.NCS(NCS), .ADDR_W(ADDR_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_cs     (cfg_cs),
        .cfg_wdata  (cfg_wdata),
        .hst_rd     (hst_rd),
        .hst_addr   (hst_addr),
        .hst_rdata  (hst_rdata),
        .hst_rdy    (hst_rdy),
        .hst_err    (hst_err),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_io_out (spi_io_out),
        .spi_io_oe  (spi_io_oe),
        .spi_io_in  (fio)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0]    m_ctrl [NCS];
    logic [31:0]    m_seg  [NCS];
    logic [NCS-1:0] m_wide;

    typedef struct {
        logic [31:0] d;
        logic        e;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    function automatic logic [7:0] fb(input logic [31:0] a);
        return (a[7:0] ^ 8'hA5) + a[15:8] + a[23:16] + a[31:24];
    endfunction

    function automatic logic [31:0] ctrl_word(input logic [7:0] op, input int dm,
                                              input int ln, input logic [1:0] md);
        logic [31:0] w;
        w = {8'h00, op, 16'h0000};
        w[7:6] = 2'(dm);
        w[14]  = dm[2];
        w[29]  = (ln == 2);
        w[30]  = (ln == 4);
        w[1:0] = md;
        return w;
    endfunction

    function automatic logic [31:0] seg_word(input int first, input int last);
        return (32'(last) << 20) | (32'(first) << 4);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input int cs, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_cs = CS_W'(cs); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 2'd0) m_ctrl[cs] = d;
        if (sel == 2'd1) m_seg[cs]  = d;
        if (sel == 2'd2) m_wide     = d[NCS-1:0];
    endtask

    // Driver: expected result from the requirements, then the host strobe.
    task automatic host_read(input logic [ADDR_W-1:0] a, input string tag);
        exp_t        x;
        int          c;
        logic [31:0] fa;
        logic [7:0]  op;
        c = -1;
        for (int i = NCS - 1; i >= 0; i--)
            if (m_seg[i] != 0 && a[27:20] >= m_seg[i][11:4] && a[27:20] <= m_seg[i][27:20]) c = i;
        x.tag = tag;
        if (c < 0 || a[1:0] != 2'b00 || m_ctrl[c][1:0] != 2'b01) begin
            x.d = 32'h0; x.e = 1'b1;
        end else begin
            fa  = 32'(a) - (32'(m_seg[c][11:4]) << 20);
            op  = m_ctrl[c][23:16];
            x.d = {fb(fa + 3) ^ op, fb(fa + 2) ^ op, fb(fa + 1) ^ op, fb(fa) ^ op};
            x.e = 1'b0;
        end
        sb_q.push_back(x);
        @(negedge clk);
        hst_addr = a; hst_rd = 1'b1;
        @(negedge clk);
        hst_rd = 1'b0;
        while (!hst_rdy) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    // Monitor: compare every completion with the oldest expectation (R8).
    always @(negedge clk) begin
        exp_t x;
        if (rst_n === 1'b1 && hst_rdy === 1'b1) begin
            if (sb_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R8 unexpected ready actual=1 expected=0");
            end else begin
                x = sb_q.pop_front();
                check({x.tag, " data"}, hst_rdata, x.d);
                check({x.tag, " err"}, 32'(hst_err), 32'(x.e));
            end
        end
    end

    // Pin monitors for R9 and R10.
    int r9_bad = 0;
    int r10_bad = 0;
    int hi_run = 3;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (spi_sclk && (&spi_cs_n)) r9_bad++;
            if ($countones(~spi_cs_n) > 1) r9_bad++;
            if (&spi_cs_n) hi_run++;
            else begin
                if (hi_run > 0 && hi_run < 2) r10_bad++;
                hi_run = 0;
            end
        end
    end

    // Flash model: capture the header, skip dummies, drive data on falls.
    wire all_hi = &spi_cs_n;
    initial begin : flash_model
        int          cs;
        int          ab;
        int          dm;
        int          ln;
        logic [7:0]  op;
        logic [7:0]  cur;
        logic [31:0] ad;
        fio = 4'h0;
        forever begin
            @(negedge all_hi);
            cs = 0;
            for (int i = 0; i < NCS; i++) if (!spi_cs_n[i]) cs = i;
            ab = m_wide[cs] ? 4 : 3;
            dm = int'({m_ctrl[cs][14], m_ctrl[cs][7:6]});
            ln = m_ctrl[cs][30] ? 4 : (m_ctrl[cs][29] ? 2 : 1);
            op = 8'h00;
            ad = 32'h0;
            for (int i = 0; i < 8; i++) begin
                @(posedge spi_sclk); op = {op[6:0], spi_io_out[0]};
            end
            for (int i = 0; i < 8 * ab; i++) begin
                @(posedge spi_sclk); ad = {ad[30:0], spi_io_out[0]};
            end
            for (int i = 0; i < 8 * dm; i++) @(posedge spi_sclk);
            for (int b = 0; b < 4; b++) begin
                cur = fb(ad + 32'(b)) ^ op;
                for (int s = 0; s < 8 / ln; s++) begin
                    @(negedge spi_sclk);
                    if (ln == 4)      fio = cur[7:4];
                    else if (ln == 2) fio = {2'b00, cur[7:6]};
                    else              fio = {2'b00, cur[7], 1'b0};
                    cur = 8'(cur << ln);
                end
            end
            @(posedge all_hi);
            fio = 4'h0;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_cs = '0; cfg_wdata = '0;
        hst_rd = 1'b0; hst_addr = '0;
        for (int i = 0; i < NCS; i++) begin m_ctrl[i] = 32'h0003_0001; m_seg[i] = 32'h0; end
        m_wide = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 chip selects after reset", 32'(spi_cs_n), 32'(5'h1F));
        check("R11 sclk after reset", 32'(spi_sclk), 32'h0);
        check("R11 ready after reset", 32'(hst_rdy), 32'h0);
        host_read(28'h000_0010, "R11 windows disabled after reset");

        cfg_write(2'd0, 0, ctrl_word(8'h03, 0, 1, 2'b01));
        cfg_write(2'd1, 0, seg_word(0, 1));
        cfg_write(2'd0, 1, ctrl_word(8'h0B, 1, 2, 2'b01));
        cfg_write(2'd1, 1, seg_word(2, 3));
        cfg_write(2'd0, 2, ctrl_word(8'h6B, 5, 4, 2'b01));
        cfg_write(2'd1, 2, seg_word(4, 4));
        cfg_write(2'd0, 3, ctrl_word(8'hEB, 7, 4, 2'b01));
        cfg_write(2'd1, 3, seg_word(4, 5));
        cfg_write(2'd0, 4, ctrl_word(8'h3B, 2, 2, 2'b01));
        cfg_write(2'd1, 4, seg_word(9, 9));
        cfg_write(2'd2, 0, 32'h0000_0004);

        host_read(28'h000_0120, "R1 single lane window 0");
        host_read(28'h01F_FFFC, "R1 last word of inclusive end page");
        host_read(28'h020_0044, "R7 dual lanes with R6 one dummy");
        host_read(28'h041_2348, "R3 overlap picks lower, R5 4-byte, R7 quad");
        host_read(28'h050_0100, "R6 seven dummies quad on upper window");
        host_read(28'h09A_BCD0, "R6 two dummies dual");
        host_read(28'h000_0122, "R4 unaligned address");
        host_read(28'h060_0000, "R4 no window for page");
        cfg_write(2'd1, 4, 32'h0);
        host_read(28'h09A_BCD0, "R2 zero window register disables");
        cfg_write(2'd0, 0, ctrl_word(8'h03, 0, 1, 2'b11));
        host_read(28'h000_0120, "R4 mode not command read");
        cfg_write(2'd0, 0, ctrl_word(8'h03, 0, 1, 2'b01));
        cfg_write(2'd2, 0, 32'h0000_0005);
        host_read(28'h000_0200, "R5 4-byte address single lane");

        repeat (10) @(negedge clk);
        check("R9 sclk framing and single select", 32'(r9_bad), 32'h0);
        check("R10 select gap", 32'(r10_bad), 32'h0);
        check("R8 every read completed", 32'(sb_q.size()), 32'h0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule